// File: doc/BRIEF.md
# Four-Level Nested Interrupt Priority Controller

This block decides which interrupt request a small 8-bit processor core takes next. Each of ten request sources is given one of four priority levels. The level comes from one bit in a high-priority bank and one bit in a low-priority bank. A global enable and a per-source enable mask filter the raw request lines. From the requests that remain, the block picks one winner and issues a one-cycle take strobe to the core, with the 16-bit vector address of the chosen source.

The block keeps one in-service bit per level, so routines can nest up to four deep. A request interrupts a running routine only when its level is strictly above the highest level in service. A return pulse from the core closes the innermost open level. Among requests that share the top pending level, a fixed polling order picks the winner. The priority banks, the mask and the global enable are loaded through a simple write port.

Top module: `irqLevelArbiter`

## Requirements
- R1: While reset is asserted and after it is released, takeStrobe and takeVector are 0, no level is in service, every source sits at level 0, the mask is clear and the global enable is off.
- R2: A source's level is {high bit, low bit}: 00 is level 0 (lowest), 01 is level 1, 10 is level 2 and 11 is level 3 (highest).
- R3: A request is taken only if its level is strictly above the highest level in service. A request at the same or a lower level is held off until that level is closed.
- R4: While level 3 is in service, no request of any source is taken.
- R5: When enabled requests of different levels are pending together, one at the highest pending level is taken.
- R6: Within one level, the winner is the pending source that comes first in this order: ext0 (bit 0), timer0 (bit 1), ext1 (bit 2), timer1 (bit 3), serial (bit 4), timer2 (bit 5), counter array (bit 6), keyboard (bit 7), SPI (bit 8), I2C (bit 9).
- R7: Vectors are ext0 0x0003, timer0 0x000B, ext1 0x0013, timer1 0x001B, serial 0x0023, timer2 0x002B, counter array 0x0033, keyboard 0x003B, and 0x0043 for both SPI and I2C.
- R8: A request causes a take only if its mask bit and the global enable are both set.
- R9: takeStrobe goes high in the clock cycle after the request is sampled and stays high for exactly one cycle. takeVector holds the winner's vector in that cycle. No take happens in the cycle right after a take.
- R10: A retiPulse clears the highest in-service level, so a request of that level can be taken again. A retiPulse with no level in service has no effect.
- R11: A write with regSel 0 loads the high bank, 1 loads the low bank, 2 loads the enable mask, and 3 loads the global enable from regWrData bit 0. The new value is used from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqReq | input | 10 | Request lines, one per source, bit order as in R6 |
| regWrEn | input | 1 | Write strobe for the configuration registers |
| regSel | input | 2 | Register select (R11) |
| regWrData | input | 10 | Write data |
| retiPulse | input | 1 | Return-from-interrupt pulse from the core |
| takeStrobe | output | 1 | One-cycle interrupt-take strobe |
| takeVector | output | 16 | Vector address of the taken source |

## Verification
The take decision is registered once. Requests and return pulses applied in one cycle therefore show up on takeStrobe and takeVector after the next rising edge, and a register write changes decisions from the cycle after it. The driver applies one stimulus per cycle on the falling edge and queues exactly one expected result for it. The monitor compares that result just after the following rising edge, so each expectation is matched to the single cycle in which it is due. The sequence is laid out to reach the back-to-back block, the level-3 lock and return pulses with nothing in service at known points.

// File: rtl/irqArbPkg.sv
package irqArbPkg;

  localparam int NUM_LEVELS = 4;
  localparam int LEVEL_W    = 2;
  localparam int VEC_W      = 16;

  typedef logic [LEVEL_W-1:0] level_t;

  // strobes from control to datapath
  typedef struct packed {
    logic takeFire;   // load winner vector this edge
    logic retiClear;  // innermost level closes this edge
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    SEL_HIGH   = 2'd0,
    SEL_LOW    = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_GLOBAL = 2'd3
  } regSel_e;

endpackage

// File: rtl/irqArbDatapath.sv
module irqArbDatapath
  import irqArbPkg::*;
#(
  parameter int NUM_SRC     = 10,
  parameter int SHARED_SLOT = 8,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STRIDE  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               regWrEn,
  input  logic [1:0]         regSel,
  input  logic [NUM_SRC-1:0] regWrData,
  input  ctlStrobe_t         strobes,
  output logic               candValid,
  output level_t             candLevel,
  output logic [VEC_W-1:0]   takeVector
);

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] prioHigh;
  logic [NUM_SRC-1:0] prioLow;
  logic [NUM_SRC-1:0] enMask;
  logic               globalOn;

  // configuration write port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prioHigh <= '0;
      prioLow  <= '0;
      enMask   <= '0;
      globalOn <= 1'b0;
    end else if (regWrEn) begin
      case (regSel_e'(regSel))
        SEL_HIGH:   prioHigh <= regWrData;
        SEL_LOW:    prioLow  <= regWrData;
        SEL_MASK:   enMask   <= regWrData;
        SEL_GLOBAL: globalOn <= regWrData[0];
        default:    ;
      endcase
    end
  end

  logic [NUM_SRC-1:0] liveReq;
  assign liveReq = irqReq & enMask & {NUM_SRC{globalOn}};

  level_t srcLevel [NUM_SRC];
  logic [NUM_SRC-1:0] reqByLevel [NUM_LEVELS];

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign srcLevel[s] = {prioHigh[s], prioLow[s]};
    for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
      assign reqByLevel[l][s] = liveReq[s] && (srcLevel[s] == level_t'(l));
    end
  end

  // highest pending level; ascending scan so the top one wins
  always_comb begin
    candValid = 1'b0;
    candLevel = '0;
    for (int l = 0; l < NUM_LEVELS; l++) begin
      if (|reqByLevel[l]) begin
        candValid = 1'b1;
        candLevel = level_t'(l);
      end
    end
  end

  // polling order inside the level: lowest index first
  logic [NUM_SRC-1:0] levelSet;
  logic [IDX_W-1:0]   winnerIdx;

  always_comb begin
    levelSet  = reqByLevel[candLevel];
    winnerIdx = '0;
    for (int s = NUM_SRC - 1; s >= 0; s--) begin
      if (levelSet[s]) winnerIdx = IDX_W'(s);
    end
  end

  function automatic logic [VEC_W-1:0] vecOf(input logic [IDX_W-1:0] idx);
    int slot;
    slot = (int'(idx) >= SHARED_SLOT) ? SHARED_SLOT : int'(idx);
    return VEC_W'(VEC_BASE + VEC_STRIDE * slot);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      takeVector <= '0;
    end else if (strobes.takeFire) begin
      takeVector <= vecOf(winnerIdx);
    end
  end

endmodule

// File: rtl/irqArbControl.sv
module irqArbControl
  import irqArbPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  candValid,
  input  level_t                candLevel,
  input  logic                  retiPulse,
  output ctlStrobe_t            strobes,
  output logic                  takeStrobe,
  output logic [NUM_LEVELS-1:0] inService
);

  logic   activeValid;
  level_t activeLevel;
  logic   canPreempt;
  logic [NUM_LEVELS-1:0] setMask;
  logic [NUM_LEVELS-1:0] clearMask;

  // innermost open level
  always_comb begin
    activeValid = |inService;
    activeLevel = '0;
    for (int l = 0; l < NUM_LEVELS; l++) begin
      if (inService[l]) activeLevel = level_t'(l);
    end
  end

  always_comb begin
    canPreempt        = !activeValid || (candLevel > activeLevel);
    strobes.takeFire  = candValid && canPreempt && !takeStrobe;
    strobes.retiClear = retiPulse && activeValid;
    setMask   = strobes.takeFire  ? (NUM_LEVELS'(1) << candLevel)   : '0;
    clearMask = strobes.retiClear ? (NUM_LEVELS'(1) << activeLevel) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inService  <= '0;
      takeStrobe <= 1'b0;
    end else begin
      inService  <= (inService & ~clearMask) | setMask;
      takeStrobe <= strobes.takeFire;
    end
  end

endmodule

// File: rtl/irqLevelArbiter.sv
module irqLevelArbiter
  import irqArbPkg::*;
#(
  parameter int NUM_SRC     = 10,
  parameter int SHARED_SLOT = 8,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STRIDE  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               regWrEn,
  input  logic [1:0]         regSel,
  input  logic [NUM_SRC-1:0] regWrData,
  input  logic               retiPulse,
  output logic               takeStrobe,
  output logic [15:0]        takeVector
);

  ctlStrobe_t            strobes;
  logic                  candValid;
  level_t                candLevel;
  logic [NUM_LEVELS-1:0] inService;

  irqArbDatapath #(
    .NUM_SRC    (NUM_SRC),
    .SHARED_SLOT(SHARED_SLOT),
    .VEC_BASE   (VEC_BASE),
    .VEC_STRIDE (VEC_STRIDE)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .irqReq    (irqReq),
    .regWrEn   (regWrEn),
    .regSel    (regSel),
    .regWrData (regWrData),
    .strobes   (strobes),
    .candValid (candValid),
    .candLevel (candLevel),
    .takeVector(takeVector)
  );

  irqArbControl u_control (
    .clk       (clk),
    .rstN      (rstN),
    .candValid (candValid),
    .candLevel (candLevel),
    .retiPulse (retiPulse),
    .strobes   (strobes),
    .takeStrobe(takeStrobe),
    .inService (inService)
  );

endmodule

// File: rtl/irqLevelArbiterChk.sv
module irqLevelArbiterChk #(
  parameter int NUM_SRC = 10
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] irqReq,
  input logic               retiPulse,
  input logic               takeStrobe,
  input logic [15:0]        takeVector,
  input logic [3:0]         inService
);

  // R1
  always @(posedge clk) begin
    if (!rstN) begin
      reset_quiet_chk: assert (!takeStrobe && inService == 4'd0);
    end
  end

  // R9
  take_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeStrobe |=> !takeStrobe);

  // R4
  top_level_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    inService[3] |=> !takeStrobe);

  // R8
  take_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeStrobe |-> $past(|irqReq));

  // R7
  vector_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeStrobe |-> (takeVector[2:0] == 3'b011 && takeVector <= 16'h0043));

  // R10
  service_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !retiPulse |=> (takeStrobe || $stable(inService)));

  // R3
  service_grows_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeStrobe |-> (inService > $past(inService)));

endmodule

bind irqLevelArbiter irqLevelArbiterChk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .irqReq    (irqReq),
  .retiPulse (retiPulse),
  .takeStrobe(takeStrobe),
  .takeVector(takeVector),
  .inService (inService)
);

// File: tb/irqLevelArbiter_tb.sv
module irqLevelArbiter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 10;
  localparam logic [NS-1:0] ALL = '1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] irqReq = '0;
  logic          regWrEn = 1'b0;
  logic [1:0]    regSel = '0;
  logic [NS-1:0] regWrData = '0;
  logic          retiPulse = 1'b0;
  logic          takeStrobe;
  logic [15:0]   takeVector;

  int vecCount = 0;
  int missCount = 0;
  bit done = 1'b0;

  bit          expTakeQ[$];
  logic [15:0] expVecQ[$];
  string       tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irqLevelArbiter u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .irqReq    (irqReq),
    .regWrEn   (regWrEn),
    .regSel    (regSel),
    .regWrData (regWrData),
    .retiPulse (retiPulse),
    .takeStrobe(takeStrobe),
    .takeVector(takeVector)
  );

  // one stimulus cycle, one queued expectation
  task automatic step(input logic [NS-1:0] req, input bit reti,
                      input bit expTake, input logic [15:0] expVec, input string tag);
    @(negedge clk);
    irqReq    = req;
    retiPulse = reti;
    regWrEn   = 1'b0;
    expTakeQ.push_back(expTake);
    expVecQ.push_back(expVec);
    tagQ.push_back(tag);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [NS-1:0] data, input string tag);
    @(negedge clk);
    irqReq    = '0;
    retiPulse = 1'b0;
    regWrEn   = 1'b1;
    regSel    = sel;
    regWrData = data;
    expTakeQ.push_back(1'b0);
    expVecQ.push_back(16'h0);
    tagQ.push_back(tag);
  endtask

  // monitor: result due just after the next rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expTakeQ.size() > 0) begin
        bit          et;
        logic [15:0] ev;
        string       tg;
        et = expTakeQ.pop_front();
        ev = expVecQ.pop_front();
        tg = tagQ.pop_front();
        vecCount++;
        if (et) begin
          if (takeStrobe !== 1'b1 || takeVector !== ev) begin
            missCount++;
            $display("FAIL %s: strobe=%b vector=%h, expected strobe=1 vector=%h",
                     tg, takeStrobe, takeVector, ev);
          end
        end else if (takeStrobe !== 1'b0) begin
          missCount++;
          $display("FAIL %s: strobe=%b vector=%h, expected strobe=0",
                   tg, takeStrobe, takeVector);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      missCount++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

  initial begin
    logic [15:0] l0Vec [6];
    l0Vec = '{16'h0003, 16'h000B, 16'h0013, 16'h001B, 16'h0023, 16'h002B};

    // R1: reset state
    repeat (3) @(negedge clk);
    vecCount++;
    if (takeStrobe !== 1'b0 || takeVector !== 16'h0) begin
      missCount++;
      $display("FAIL R1 reset: strobe=%b vector=%h, expected 0/0000", takeStrobe, takeVector);
    end
    rstN = 1'b1;
    step('0, 1'b0, 1'b0, 16'h0, "R1 idle after reset");

    // R8: mask and global enable off after reset
    step(ALL, 1'b0, 1'b0, 16'h0, "R8 all disabled");
    wr(2'd2, ALL, "R11 write mask");
    step(ALL, 1'b0, 1'b0, 16'h0, "R8 global enable off");
    wr(2'd3, 10'h001, "R11 write global enable");

    // R6: timer1 before timer2, both level 0
    step(10'h028, 1'b0, 1'b1, 16'h001B, "R6 poll t1 over t2");
    step('0, 1'b0, 1'b0, 16'h0, "R9 single cycle");
    step(10'h001, 1'b0, 1'b0, 16'h0, "R3 same level waits");
    step(10'h001, 1'b0, 1'b0, 16'h0, "R3 same level still waits");

    // R2: kbd L1, pca L2, spi/i2c L3
    wr(2'd1, 10'h380, "R11 write low bank");
    wr(2'd0, 10'h340, "R11 write high bank");
    step(10'h081, 1'b0, 1'b1, 16'h003B, "R2 level1 preempts level0");
    step(10'h040, 1'b0, 1'b0, 16'h0, "R9 no take right after take");
    step(10'h040, 1'b0, 1'b1, 16'h0033, "R2 level2 preempts level1");
    step('0, 1'b0, 1'b0, 16'h0, "R9 idle");
    step(10'h040, 1'b0, 1'b0, 16'h0, "R3 equal level blocked");
    step(10'h080, 1'b0, 1'b0, 16'h0, "R3 lower level blocked");
    step(10'h300, 1'b0, 1'b1, 16'h0043, "R2 level3 preempts");
    step('0, 1'b0, 1'b0, 16'h0, "R4 idle");
    step(ALL, 1'b0, 1'b0, 16'h0, "R4 level3 locks");
    step(ALL, 1'b0, 1'b0, 16'h0, "R4 level3 still locks");

    // R10: returns
    step('0, 1'b1, 1'b0, 16'h0, "R10 close level3");
    step(10'h200, 1'b0, 1'b1, 16'h0043, "R10 level3 free again");
    step('0, 1'b1, 1'b0, 16'h0, "R10 close level3");
    step('0, 1'b1, 1'b0, 16'h0, "R10 close level2");
    step(10'h040, 1'b0, 1'b1, 16'h0033, "R10 level2 free again");
    step('0, 1'b1, 1'b0, 16'h0, "R10 close");
    step('0, 1'b1, 1'b0, 16'h0, "R10 close");
    step('0, 1'b1, 1'b0, 16'h0, "R10 close");
    step('0, 1'b1, 1'b0, 16'h0, "R10 empty return no effect");

    // R5: highest level wins
    step(10'h0C1, 1'b0, 1'b1, 16'h0033, "R5 level2 over 1 and 0");
    step('0, 1'b1, 1'b0, 16'h0, "R10 close");
    step(10'h081, 1'b0, 1'b1, 16'h003B, "R5 level1 over 0");
    step('0, 1'b1, 1'b0, 16'h0, "R10 close");
    step(10'h034, 1'b0, 1'b1, 16'h0013, "R6 poll ext1 first");
    step('0, 1'b1, 1'b0, 16'h0, "R10 close");

    // R7: level-0 vectors one by one
    for (int i = 0; i < 6; i++) begin
      step(NS'(1) << i, 1'b0, 1'b1, l0Vec[i], "R7 vector map");
      step('0, 1'b1, 1'b0, 16'h0, "R10 close");
    end

    // R8: mask bit
    wr(2'd2, ALL & ~NS'(2), "R11 mask off timer0");
    step(10'h002, 1'b0, 1'b0, 16'h0, "R8 masked source ignored");
    step(10'h00A, 1'b0, 1'b1, 16'h001B, "R8 masked timer0 skipped");
    step('0, 1'b1, 1'b0, 16'h0, "R10 close");
    wr(2'd3, 10'h000, "R11 global enable off");
    step(ALL, 1'b0, 1'b0, 16'h0, "R8 global off blocks");
    step('0, 1'b0, 1'b0, 16'h0, "R8 idle");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

endmodule